// File: doc/BRIEF.md
# Claim/Complete Interrupt Distributor for Multiple Harts

The block collects up to 31 level-sensitive device interrupt lines and distributes them to several processor contexts (harts). Software sets a priority for each source, an enable mask and a priority threshold for each hart. The block raises one notification line per hart whenever that hart has a deliverable source.

A hart takes an interrupt by reading its claim register. The read returns the ID of the best qualifying source and puts that source in service, so it is offered to no hart until the same ID is written back to a claim register. Source ID 0 means "nothing pending". The register bus is a plain 32-bit word interface with separate read and write strobes and a shared byte address. Read data is combinational, and the side effects of an access take place at the clock edge that ends the access cycle. A read and a write may be issued in the same cycle.

Top module: `irq_claim_ctrl`

## Requirements
- R1: The priority of source N (1..31) is at byte address 4*N and holds 3 bits. Bits above bit 2 ignore writes and read as zero. Address 0 (ID 0) always reads zero.
- R2: A source whose priority is 0 is never signalled to, or claimed by, any hart.
- R3: The enable mask of hart H is at 0x1000 + 0x80*H, with bit N enabling source N. Bit 0 reads zero. A source whose bit is clear for a hart is never signalled to or claimed by that hart.
- R4: The threshold of hart H is at 0x2000 + 0x1000*H and holds 3 bits, with upper bits ignored. A source qualifies for the hart only when its priority is strictly greater than the threshold.
- R5: Reading 0x2004 + 0x1000*H returns the ID of the winning qualifying source for hart H, or 0 when there is none. A nonzero result puts that source in service from the next cycle, and it is then offered to no hart.
- R6: Writing a source ID to any hart's claim address ends service of that source. While a source is in service its line cannot make it pending again.
- R7: Among the qualifying sources the highest priority wins. Among equal priorities the lowest ID wins.
- R8: irq_o[H] is high in exactly the cycles in which hart H has at least one qualifying source, derived combinationally from registered state.
- R9: A source's pending flag is set at a clock edge where its line is high and it is not in service. The flag stays set after the line drops, and only a claim clears it. If the line is still high after completion, the source becomes pending again one cycle later.
- R10: A completion write carrying an ID outside 1..31, or the ID of a source not in service, changes nothing.
- R11: After reset all priorities, masks, thresholds, pending and in-service flags are zero, and every irq_o bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 31 | Level interrupt lines; bit N is source N (indices 31:1) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a claim read takes effect at the clock edge |
| addr | input | 16 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle rd_en is high |
| irq_o | output | 2 | Per-hart notification |

## Verification
A claim read and a completion write can fall in the same cycle on the same claim address. The bench issues both strobes together, reading the claim while writing back the ID of a different source whose line is still high. The read must return the currently winning ID. The freed source must become pending again one cycle later, while the newly claimed one stays in service. A behavioural model built on arrays predicts every irq_o bit on every cycle and every read value, and both are compared at the falling edge.

// File: rtl/icc_pkg.sv
package icc_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } rg_e;

  // Region decode: 0x0xxx priorities, 0x1xxx masks, 0x2000+ per-hart pages
  function automatic rg_e decode_region(input logic [ADDR_W-1:0] a);
    rg_e r;
    r = RG_NONE;
    if (a[1:0] == 2'b00) begin
      if (a[15:12] == 4'd0) begin
        if (a[11:7] == 5'd0) r = RG_PRIO;
      end else if (a[15:12] == 4'd1) begin
        if (a[6:0] == 7'd0) r = RG_EN;
      end else begin
        if (a[11:0] == 12'h000) r = RG_THR;
        else if (a[11:0] == 12'h004) r = RG_CLAIM;
      end
    end
    return r;
  endfunction

  function automatic logic [4:0] decode_hart(input logic [ADDR_W-1:0] a);
    logic [3:0] pg;
    pg = a[15:12] - 4'd2;
    return (a[15:12] == 4'd1) ? a[11:7] : {1'b0, pg};
  endfunction

  function automatic logic passes_thr(input logic [7:0] p, input logic [7:0] t);
    return p > t;
  endfunction

endpackage

// File: rtl/icc_gateway.sv
module icc_gateway #(
  parameter int NSRC = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC:1] src_i,
  input  logic [NSRC:1] claim_hit,
  input  logic [NSRC:1] cmp_hit,
  output logic [NSRC:1] pend_o,
  output logic [NSRC:1] busy_o
);

  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    logic pend_q, busy_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        busy_q <= 1'b0;
      end else begin
        if (claim_hit[s]) pend_q <= 1'b0;
        else if (src_i[s] && !busy_q) pend_q <= 1'b1;

        if (claim_hit[s]) busy_q <= 1'b1;
        else if (cmp_hit[s]) busy_q <= 1'b0;
      end
    end

    assign pend_o[s] = pend_q;
    assign busy_o[s] = busy_q;

    AST_CLAIM_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      claim_hit[s] |=> busy_q && !pend_q) else $error("claim did not take source"); // R5
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !cmp_hit[s] |=> busy_q) else $error("service ended without completion"); // R6
    AST_NO_PEND_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !pend_q) else $error("pending while in service"); // R6
  end

endmodule

// File: rtl/icc_target_sel.sv
module icc_target_sel #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int IDW    = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSRC:1]                live,
  input  logic [NSRC:1]                en,
  input  logic [NSRC:1][PRIO_W-1:0]    prio,
  input  logic [PRIO_W-1:0]            thr,
  output logic [IDW-1:0]               win_id,
  output logic                         notify
);

  logic [NSRC:1]       qual;
  logic [PRIO_W-1:0]   best_p;
  logic                found;

  always_comb begin
    for (int s = 1; s <= NSRC; s++)
      qual[s] = live[s] && en[s] &&
                icc_pkg::passes_thr(8'(prio[s]), 8'(thr));
  end

  // Strict greater-than keeps the first (lowest) ID among equal priorities
  always_comb begin
    best_p = '0;
    found  = 1'b0;
    win_id = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (qual[s] && (!found || prio[s] > best_p)) begin
        found  = 1'b1;
        best_p = prio[s];
        win_id = IDW'(s);
      end
    end
  end

  assign notify = |qual;

  AST_WIN_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    win_id != '0 |-> prio[win_id] > thr) else $error("winner under threshold"); // R4
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    win_id != '0 |-> en[win_id] && live[win_id]) else $error("winner not enabled"); // R3
  AST_NOTIFY_HAS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> win_id != '0) else $error("notify without winner"); // R8

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
  import icc_pkg::*;
#(
  parameter int NSRC   = 31,
  parameter int NHART  = 2,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [15:0]       addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NHART-1:0]  irq_o
);

  localparam int IDW = $clog2(NSRC + 1);

  logic [NSRC:1][PRIO_W-1:0]   prio_q;
  logic [NHART-1:0][NSRC:1]    en_q;
  logic [NHART-1:0][PRIO_W-1:0] thr_q;
  logic [NHART-1:0][IDW-1:0]   win_id;

  logic [NSRC:1] pend, busy, live, claim_hit, cmp_hit;

  rg_e        rg;
  logic [4:0] hsel;
  logic [4:0] src_idx;
  logic       hart_ok;
  logic       claim_rd, cmp_wr;
  logic [IDW-1:0] sel_win;

  assign rg      = decode_region(addr);
  assign hsel    = decode_hart(addr);
  assign src_idx = addr[6:2];
  assign hart_ok = int'(hsel) < NHART;

  always_comb begin
    sel_win = '0;
    for (int h = 0; h < NHART; h++)
      if (hsel == 5'(h)) sel_win = win_id[h];
  end

  assign claim_rd = rd_en && (rg == RG_CLAIM) && hart_ok;
  assign cmp_wr   = wr_en && (rg == RG_CLAIM) && hart_ok;

  always_comb begin
    for (int s = 1; s <= NSRC; s++) begin
      claim_hit[s] = claim_rd && (sel_win == IDW'(s));
      cmp_hit[s]   = cmp_wr && (wdata == 32'(s)) && busy[s];
    end
  end

  icc_gateway #(.NSRC(NSRC)) u_gw (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .claim_hit(claim_hit), .cmp_hit(cmp_hit),
    .pend_o(pend), .busy_o(busy)
  );

  assign live = pend & ~busy;

  for (genvar h = 0; h < NHART; h++) begin : g_hart
    icc_target_sel #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_sel (
      .clk(clk), .rst_n(rst_n), .live(live), .en(en_q[h]),
      .prio(prio_q), .thr(thr_q[h]),
      .win_id(win_id[h]), .notify(irq_o[h])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr_en && hart_ok || wr_en && rg == RG_PRIO) begin
      case (rg)
        RG_PRIO:
          for (int s = 1; s <= NSRC; s++)
            if (src_idx == 5'(s)) prio_q[s] <= wdata[PRIO_W-1:0];
        RG_EN:
          for (int h = 0; h < NHART; h++)
            if (hsel == 5'(h)) en_q[h] <= wdata[NSRC:1];
        RG_THR:
          for (int h = 0; h < NHART; h++)
            if (hsel == 5'(h)) thr_q[h] <= wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (rg)
      RG_PRIO:
        for (int s = 1; s <= NSRC; s++)
          if (src_idx == 5'(s)) rdata = DATA_W'(prio_q[s]);
      RG_EN:
        for (int h = 0; h < NHART; h++)
          if (hsel == 5'(h)) rdata[NSRC:1] = en_q[h];
      RG_THR:
        for (int h = 0; h < NHART; h++)
          if (hsel == 5'(h)) rdata = DATA_W'(thr_q[h]);
      RG_CLAIM:
        if (hart_ok) rdata = DATA_W'(sel_win);
      default: ;
    endcase
  end

  AST_CLAIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_hit)) else $error("claim hit several sources"); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> irq_o == '0) else $error("notify after reset"); // R11

endmodule

// File: tb/irq_claim_ctrl_tb.sv
`timescale 1ns/1ps
module irq_claim_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:1] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_claim_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  // Behavioural reference
  int          m_prio [32];
  logic [31:0] m_en   [2];
  int          m_thr  [2];
  bit          m_pend [32];
  bit          m_busy [32];

  function automatic int m_win(int h);
    int best = 0;
    for (int s = 31; s >= 1; s--)
      if (m_pend[s] && !m_busy[s] && m_en[h][s] && m_prio[s] > m_thr[h] &&
          (best == 0 || m_prio[s] >= m_prio[best]))
        best = s;
    return best;
  endfunction

  function automatic logic [31:0] m_read(logic [15:0] a);
    int ai = int'(a);
    if (a[1:0] != 0) return 0;
    if (ai < 'h80) return (ai == 0) ? 0 : 32'(m_prio[ai/4]);
    for (int h = 0; h < 2; h++) begin
      if (ai == 'h1000 + 'h80*h) return m_en[h] & 32'hFFFF_FFFE;
      if (ai == 'h2000 + 'h1000*h) return 32'(m_thr[h]);
      if (ai == 'h2004 + 'h1000*h) return 32'(m_win(h));
    end
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    int ai = int'(addr);
    int w = 0;
    int cid = -1;
    bit np [32];
    bit nb [32];
    if (rd_en)
      for (int h = 0; h < 2; h++)
        if (ai == 'h2004 + 'h1000*h) w = m_win(h);
    if (wr_en)
      for (int h = 0; h < 2; h++)
        if (ai == 'h2004 + 'h1000*h && wdata >= 1 && wdata <= 31 && m_busy[int'(wdata)])
          cid = int'(wdata);
    for (int s = 1; s <= 31; s++) begin
      np[s] = (s == w) ? 1'b0 : (m_pend[s] || (src[s] && !m_busy[s]));
      nb[s] = (s == w) ? 1'b1 : (s == cid) ? 1'b0 : m_busy[s];
    end
    for (int s = 1; s <= 31; s++) begin
      m_pend[s] = np[s];
      m_busy[s] = nb[s];
    end
    if (wr_en) begin
      if (ai > 0 && ai < 'h80 && addr[1:0] == 0) m_prio[ai/4] = int'(wdata & 7);
      for (int h = 0; h < 2; h++) begin
        if (ai == 'h1000 + 'h80*h) m_en[h] = wdata & 32'hFFFF_FFFE;
        if (ai == 'h2000 + 'h1000*h) m_thr[h] = int'(wdata & 7);
      end
    end
  endtask

  // One cycle: compare at mid-cycle, advance model, move to next falling edge
  task automatic step(string tag);
    logic [31:0] ei;
    #1;
    ei = '0;
    for (int h = 0; h < 2; h++) ei[h] = (m_win(h) != 0);
    chk("R8 irq", 32'(irq_o), ei);
    if (rd_en) chk(tag, rdata, m_read(addr));
    model_update();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step("idle");
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step("write");
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(logic [15:0] a, logic [31:0] e, string tag);
    addr = a; rd_en = 1'b1;
    #1;
    chk(tag, rdata, e);
    step(tag);
    rd_en = 1'b0;
  endtask

  initial begin
    for (int s = 0; s < 32; s++) begin
      m_prio[s] = 0; m_pend[s] = 0; m_busy[s] = 0;
    end
    m_en[0] = 0; m_en[1] = 0; m_thr[0] = 0; m_thr[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    #1 chk("R11 irq after reset", 32'(irq_o), 0);
    rd_exp(16'h0014, 0, "R11 prio after reset");
    rd_exp(16'h2004, 0, "R11 claim after reset");

    // R1 priority layout and width
    wr(16'h000C, 32'd1);
    wr(16'h0014, 32'hFFFF_FFFB);
    wr(16'h001C, 32'd3);
    wr(16'h0024, 32'd0);
    rd_exp(16'h0014, 32'd3, "R1 upper bits dropped");
    wr(16'h0000, 32'd7);
    rd_exp(16'h0000, 32'd0, "R1 id0 reads zero");
    rd_exp(16'h0100, 32'd0, "R1 unmapped reads zero");

    // R3 enable masks
    wr(16'h1000, 32'h0000_02A9);
    wr(16'h1080, 32'h0000_0208);
    rd_exp(16'h1000, 32'h0000_02A8, "R3 bit0 reads zero");

    // Raise lines 3,5,7,9
    src[3] = 1; src[5] = 1; src[7] = 1; src[9] = 1;
    idle(1);
    #1 chk("R8 both harts notified", 32'(irq_o), 32'd3);
    rd_exp(16'h2004, 32'd5, "R7 tie to lowest id");
    rd_exp(16'h2004, 32'd7, "R7 next winner");
    rd_exp(16'h3004, 32'd3, "R5 hart1 claim");
    rd_exp(16'h2004, 32'd0, "R2 zero priority never claimed");
    #1 chk("R2 zero priority no notify", 32'(irq_o), 32'd0);

    // R10 bad completions
    wr(16'h2004, 32'd12);
    wr(16'h2004, 32'd40);
    idle(2);
    #1 chk("R10 bad completion ignored", 32'(irq_o), 32'd0);
    rd_exp(16'h2004, 32'd0, "R10 nothing freed");

    // R6 completion with line high, then same-cycle claim + complete
    wr(16'h2004, 32'd7);
    idle(1);
    addr = 16'h2004; wdata = 32'd5; rd_en = 1'b1; wr_en = 1'b1;
    #1 chk("R5 claim during completion", rdata, 32'd7);
    step("R5 claim during completion");
    rd_en = 1'b0; wr_en = 1'b0;
    idle(1);
    rd_exp(16'h2004, 32'd5, "R9 re-pend after completion");
    rd_exp(16'h2004, 32'd0, "R6 busy sources stay quiet");

    // R9 latch of a short pulse
    src[3] = 0;
    wr(16'h3004, 32'd3);
    idle(2);
    rd_exp(16'h3004, 32'd0, "R9 no re-pend when line low");
    src[3] = 1;
    step("pulse");
    src[3] = 0;
    idle(1);
    rd_exp(16'h3004, 32'd3, "R9 pulse latched");

    // R4 threshold
    wr(16'h3000, 32'hFFFF_FFF9);
    rd_exp(16'h3000, 32'd1, "R4 threshold width");
    src[3] = 1;
    wr(16'h3004, 32'd3);
    idle(2);
    #1 chk("R4 equal priority blocked", 32'(irq_o[1]), 32'd0);
    rd_exp(16'h3004, 32'd0, "R4 no claim at threshold");
    wr(16'h000C, 32'd2);
    idle(1);
    #1 chk("R4 above threshold notifies", 32'(irq_o[1]), 32'd1);
    rd_exp(16'h3004, 32'd3, "R4 claim above threshold");

    // R3 source not enabled for hart1
    wr(16'h3004, 32'd5);
    idle(2);
    rd_exp(16'h3004, 32'd0, "R3 hart1 cannot take source 5");
    #1 chk("R3 hart0 still notified", 32'(irq_o[0]), 32'd1);
    rd_exp(16'h2004, 32'd5, "R3 hart0 takes source 5");
    idle(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule